// File: doc/BRIEF.md
# Byte Block Copy Engine

This engine copies a contiguous run of bytes from one memory region to another. It is the execution unit behind a block-move instruction in a small processor. A one-cycle start pulse loads four values: a source pointer, a destination pointer, a count and a width-select bit. The width-select bit decides whether the count is taken as an 8-bit value (the low byte only) or as a full 16-bit value.

The engine then loops over the bytes. For each byte it reads from the source through a request/valid memory port. It writes the returned data to the destination and waits for the write acknowledge. It then post-increments both pointers and decrements the selected part of the count. When the count reaches zero it pulses done.

A count that is already zero at start completes without any memory access. The final pointers and count remain on the outputs as the architectural result of the operation. Addresses are 24 bits wide and are carried in 32-bit pointers whose top byte is always zero.

Top module: `blkcopy_engine`

## Requirements
- R1: With `wide_i` = 0 the byte count is `cnt_i[7:0]`. Only that low byte is decremented, and `cnt_o[15:8]` keeps the value loaded from `cnt_i[15:8]`. At completion `cnt_o[7:0]` is zero.
- R2: With `wide_i` = 1 the byte count is the full `cnt_i[15:0]`, and at completion `cnt_o` is zero.
- R3: If the selected count is zero at start, the engine makes no memory request. `done_o` is then high in the second cycle after the start edge.
- R4: Each byte is moved in two phases. First comes a read (`mem_req_o`=1, `mem_we_o`=0) at the source address, held until `mem_rvalid_i`. Then comes a write (`mem_req_o`=1, `mem_we_o`=1) of that read data at the destination address, held until `mem_wack_i`. With zero-latency responses an N-byte transfer raises `done_o` 2N+2 cycles after the start edge.
- R5: After each write acknowledge, both pointers advance by one modulo 2^24. Bits 31:24 of `src_o` and `dst_o` are always zero, including when they are loaded from inputs whose bits 31:24 are nonzero.
- R6: `busy_o` rises in the cycle after an accepted start and stays high until `done_o` rises. `done_o` lasts exactly one cycle and is never high together with `busy_o`.
- R7: A start pulse while `busy_o` is high is ignored. The transfer in progress, its access count and its final results are unaffected.
- R8: After `done_o`, the values on `src_o`, `dst_o` and `cnt_o` stay unchanged until the next accepted start.
- R9: A synchronous active-high reset clears `busy_o`, `done_o` and `mem_req_o`, and clears the pointer and count outputs to zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| start_i | input | 1 | Start pulse, accepted only when idle |
| src_i | input | 32 | Initial source pointer |
| dst_i | input | 32 | Initial destination pointer |
| cnt_i | input | 16 | Initial count |
| wide_i | input | 1 | 1 = 16-bit count, 0 = 8-bit count |
| busy_o | output | 1 | Transfer in progress |
| done_o | output | 1 | One-cycle completion pulse |
| src_o | output | 32 | Current or final source pointer |
| dst_o | output | 32 | Current or final destination pointer |
| cnt_o | output | 16 | Current or final count |
| mem_req_o | output | 1 | Memory request |
| mem_we_o | output | 1 | 1 = write request, 0 = read request |
| mem_addr_o | output | 24 | Memory byte address |
| mem_wdata_o | output | 8 | Write data |
| mem_rdata_i | input | 8 | Read data, valid with mem_rvalid_i |
| mem_rvalid_i | input | 1 | Read data valid |
| mem_wack_i | input | 1 | Write acknowledge |

## Verification
- **Byte mode with a nonzero upper count byte** (`0xAB05`) separates an 8-bit count from a 16-bit one. It also shows whether the upper byte is left untouched.
- **Word mode with `0x0100`**, whose low byte is zero, does the reverse: it copies 256 bytes where a byte-mode engine would copy none.
- **Zero counts in both modes** check that completion happens without any access. The zero-count cases include a byte-mode count whose upper byte is nonzero.
- **A source range straddling `0xFFFFFF`**, loaded with a junk top byte, exposes missing wrap or masking.
- **Zero and multi-cycle memory latency** separate the exact step timing from the handshake hold behaviour.
- **A stray start mid-transfer and a guard byte after the destination** catch restarts and off-by-one lengths.

// File: rtl/blkcopy_pkg.sv
package blkcopy_pkg;
  typedef enum logic [1:0] {
    ST_IDLE = 2'd0,
    ST_RD   = 2'd1,
    ST_WR   = 2'd2,
    ST_FIN  = 2'd3
  } blk_state_e;
endpackage

// File: rtl/blkcopy_ptr.sv
// Pointer register: load with the top bits cleared, post-increment with wrap
// inside the address width (R5).
module blkcopy_ptr #(
  parameter int PTR_W  = 32,
  parameter int ADDR_W = 24
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             load_i,
  input  logic [PTR_W-1:0] val_i,
  input  logic             inc_i,
  output logic [PTR_W-1:0] ptr_o
);
  localparam int PAD_W = PTR_W - ADDR_W;
  localparam logic [PTR_W-1:0] ADDR_MASK = {{PAD_W{1'b0}}, {ADDR_W{1'b1}}};

  logic [PTR_W-1:0]  ptr_q;
  logic [ADDR_W-1:0] ptr_nx;

  assign ptr_nx = ptr_q[ADDR_W-1:0] + {{(ADDR_W-1){1'b0}}, 1'b1};

  always_ff @(posedge clk) begin
    if (rst)         ptr_q <= '0;
    else if (load_i) ptr_q <= val_i & ADDR_MASK;
    else if (inc_i)  ptr_q <= {{PAD_W{1'b0}}, ptr_nx};
  end

  assign ptr_o = ptr_q;
endmodule

// File: rtl/blkcopy_cnt.sv
// Count register with per-transfer width select (R1, R2).
module blkcopy_cnt #(
  parameter int CNT_W    = 16,
  parameter int NARROW_W = 8
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             load_i,
  input  logic [CNT_W-1:0] val_i,
  input  logic             wide_i,
  input  logic             dec_i,
  output logic [CNT_W-1:0] cnt_o,
  output logic             ld_zero_o,
  output logic             last_o
);
  localparam int HI_W = CNT_W - NARROW_W;

  logic [CNT_W-1:0]    cnt_q;
  logic                wide_q;
  logic [CNT_W-1:0]    cnt_dec;
  logic [NARROW_W-1:0] lo_dec;

  assign lo_dec = cnt_q[NARROW_W-1:0] - {{(NARROW_W-1){1'b0}}, 1'b1};

  always_comb begin
    if (wide_q) cnt_dec = cnt_q - {{(CNT_W-1){1'b0}}, 1'b1};
    else        cnt_dec = {cnt_q[CNT_W-1:NARROW_W], lo_dec};
  end

  assign ld_zero_o = wide_i ? (val_i == '0) : (val_i[NARROW_W-1:0] == '0);

  assign last_o = wide_q
                ? (cnt_q == {{(CNT_W-1){1'b0}}, 1'b1})
                : (cnt_q[NARROW_W-1:0] == {{(NARROW_W-1){1'b0}}, 1'b1});

  always_ff @(posedge clk) begin
    if (rst) begin
      cnt_q  <= '0;
      wide_q <= 1'b0;
    end else if (load_i) begin
      cnt_q  <= val_i;
      wide_q <= wide_i;
    end else if (dec_i) begin
      cnt_q  <= cnt_dec;
    end
  end

  assign cnt_o = cnt_q;

  logic unused_hi;
  assign unused_hi = ^{HI_W{1'b0}};
endmodule

// File: rtl/blkcopy_seq.sv
// Transfer sequencer: idle -> read -> write -> ... -> finish.
module blkcopy_seq
  import blkcopy_pkg::*;
(
  input  logic       clk,
  input  logic       rst,
  input  logic       start_i,
  input  logic       ld_zero_i,
  input  logic       last_i,
  input  logic       rvalid_i,
  input  logic       wack_i,
  output blk_state_e state_o,
  output logic       load_o,
  output logic       cap_o,
  output logic       step_o,
  output logic       busy_o,
  output logic       done_o
);
  blk_state_e state_q;
  logic       busy_q;
  logic       done_q;

  assign load_o = (state_q == ST_IDLE) && start_i;
  assign cap_o  = (state_q == ST_RD)   && rvalid_i;
  assign step_o = (state_q == ST_WR)   && wack_i;

  always_ff @(posedge clk) begin
    if (rst) begin
      state_q <= ST_IDLE;
      busy_q  <= 1'b0;
      done_q  <= 1'b0;
    end else begin
      done_q <= 1'b0;
      case (state_q)
        ST_IDLE: if (start_i) begin
          busy_q  <= 1'b1;
          state_q <= ld_zero_i ? ST_FIN : ST_RD;
        end
        ST_RD:   if (rvalid_i) state_q <= ST_WR;
        ST_WR:   if (wack_i)   state_q <= last_i ? ST_FIN : ST_RD;
        ST_FIN: begin
          done_q  <= 1'b1;
          busy_q  <= 1'b0;
          state_q <= ST_IDLE;
        end
        default: state_q <= ST_IDLE;
      endcase
    end
  end

  assign state_o = state_q;
  assign busy_o  = busy_q;
  assign done_o  = done_q;
endmodule

// File: rtl/blkcopy_engine.sv
module blkcopy_engine
  import blkcopy_pkg::*;
#(
  parameter int PTR_W    = 32,
  parameter int ADDR_W   = 24,
  parameter int CNT_W    = 16,
  parameter int NARROW_W = 8,
  parameter int DATA_W   = 8
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              start_i,
  input  logic [PTR_W-1:0]  src_i,
  input  logic [PTR_W-1:0]  dst_i,
  input  logic [CNT_W-1:0]  cnt_i,
  input  logic              wide_i,
  output logic              busy_o,
  output logic              done_o,
  output logic [PTR_W-1:0]  src_o,
  output logic [PTR_W-1:0]  dst_o,
  output logic [CNT_W-1:0]  cnt_o,
  output logic              mem_req_o,
  output logic              mem_we_o,
  output logic [ADDR_W-1:0] mem_addr_o,
  output logic [DATA_W-1:0] mem_wdata_o,
  input  logic [DATA_W-1:0] mem_rdata_i,
  input  logic              mem_rvalid_i,
  input  logic              mem_wack_i
);
  localparam int NUM_PTR = 2;

  blk_state_e       state;
  logic             load, cap, step, ld_zero, last;
  logic [PTR_W-1:0] ptr_in [NUM_PTR];
  logic [PTR_W-1:0] ptr_q  [NUM_PTR];
  logic [DATA_W-1:0] data_q;

  assign ptr_in[0] = src_i;
  assign ptr_in[1] = dst_i;

  blkcopy_seq u_seq (
    .clk       (clk),
    .rst       (rst),
    .start_i   (start_i),
    .ld_zero_i (ld_zero),
    .last_i    (last),
    .rvalid_i  (mem_rvalid_i),
    .wack_i    (mem_wack_i),
    .state_o   (state),
    .load_o    (load),
    .cap_o     (cap),
    .step_o    (step),
    .busy_o    (busy_o),
    .done_o    (done_o)
  );

  for (genvar g = 0; g < NUM_PTR; g++) begin : g_ptr
    blkcopy_ptr #(.PTR_W(PTR_W), .ADDR_W(ADDR_W)) u_ptr (
      .clk    (clk),
      .rst    (rst),
      .load_i (load),
      .val_i  (ptr_in[g]),
      .inc_i  (step),
      .ptr_o  (ptr_q[g])
    );
  end

  blkcopy_cnt #(.CNT_W(CNT_W), .NARROW_W(NARROW_W)) u_cnt (
    .clk       (clk),
    .rst       (rst),
    .load_i    (load),
    .val_i     (cnt_i),
    .wide_i    (wide_i),
    .dec_i     (step),
    .cnt_o     (cnt_o),
    .ld_zero_o (ld_zero),
    .last_o    (last)
  );

  always_ff @(posedge clk) begin
    if (rst)      data_q <= '0;
    else if (cap) data_q <= mem_rdata_i;
  end

  assign src_o       = ptr_q[0];
  assign dst_o       = ptr_q[1];
  assign mem_req_o   = (state == ST_RD) || (state == ST_WR);
  assign mem_we_o    = (state == ST_WR);
  assign mem_addr_o  = (state == ST_WR) ? ptr_q[1][ADDR_W-1:0] : ptr_q[0][ADDR_W-1:0];
  assign mem_wdata_o = data_q;
endmodule

// File: rtl/blkcopy_chk.sv
module blkcopy_chk #(
  parameter int PTR_W  = 32,
  parameter int ADDR_W = 24,
  parameter int CNT_W  = 16,
  parameter int DATA_W = 8
) (
  input logic              clk,
  input logic              rst,
  input logic              start_i,
  input logic              busy_o,
  input logic              done_o,
  input logic [PTR_W-1:0]  src_o,
  input logic [PTR_W-1:0]  dst_o,
  input logic [CNT_W-1:0]  cnt_o,
  input logic              mem_req_o,
  input logic              mem_we_o,
  input logic [ADDR_W-1:0] mem_addr_o,
  input logic [DATA_W-1:0] mem_wdata_o,
  input logic              mem_rvalid_i,
  input logic              mem_wack_i
);
  logic [ADDR_W-1:0] src_nx;
  logic [ADDR_W-1:0] dst_nx;

  assign src_nx = src_o[ADDR_W-1:0] + 1'b1;
  assign dst_nx = dst_o[ADDR_W-1:0] + 1'b1;

  // R6
  done_not_busy_chk: assert property (@(posedge clk) disable iff (rst)
    done_o |-> !busy_o);

  // R6
  done_pulse_chk: assert property (@(posedge clk) disable iff (rst)
    done_o |=> !done_o);

  // R3
  req_only_busy_chk: assert property (@(posedge clk) disable iff (rst)
    mem_req_o |-> busy_o);

  // R4
  rd_hold_chk: assert property (@(posedge clk) disable iff (rst)
    (mem_req_o && !mem_we_o && !mem_rvalid_i)
      |=> (mem_req_o && !mem_we_o && $stable(mem_addr_o)));

  // R4
  wr_hold_chk: assert property (@(posedge clk) disable iff (rst)
    (mem_req_o && mem_we_o && !mem_wack_i)
      |=> (mem_req_o && mem_we_o && $stable(mem_addr_o) && $stable(mem_wdata_o)));

  // R5
  ptr_step_chk: assert property (@(posedge clk) disable iff (rst)
    (mem_req_o && mem_we_o && mem_wack_i)
      |=> (src_o[ADDR_W-1:0] == $past(src_nx) && dst_o[ADDR_W-1:0] == $past(dst_nx)));

  // R5
  ptr_top_zero_chk: assert property (@(posedge clk) disable iff (rst)
    (src_o[PTR_W-1:ADDR_W] == '0) && (dst_o[PTR_W-1:ADDR_W] == '0));

  // R8
  result_hold_chk: assert property (@(posedge clk) disable iff (rst)
    (!busy_o && !start_i) |=> ($stable(src_o) && $stable(dst_o) && $stable(cnt_o)));
endmodule

bind blkcopy_engine blkcopy_chk #(
  .PTR_W(PTR_W), .ADDR_W(ADDR_W), .CNT_W(CNT_W), .DATA_W(DATA_W)
) u_chk (
  .clk          (clk),
  .rst          (rst),
  .start_i      (start_i),
  .busy_o       (busy_o),
  .done_o       (done_o),
  .src_o        (src_o),
  .dst_o        (dst_o),
  .cnt_o        (cnt_o),
  .mem_req_o    (mem_req_o),
  .mem_we_o     (mem_we_o),
  .mem_addr_o   (mem_addr_o),
  .mem_wdata_o  (mem_wdata_o),
  .mem_rvalid_i (mem_rvalid_i),
  .mem_wack_i   (mem_wack_i)
);

// File: tb/tb_blkcopy_engine.sv
module tb_blkcopy_engine;
  localparam int CLK_PERIOD = 10;
  localparam int MEM_SZ     = 4096;
  localparam int WDOG       = 150000;

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        start_i = 1'b0;
  logic [31:0] src_i = '0, dst_i = '0;
  logic [15:0] cnt_i = '0;
  logic        wide_i = 1'b0;
  logic        busy_o, done_o, mem_req_o, mem_we_o;
  logic [31:0] src_o, dst_o;
  logic [15:0] cnt_o;
  logic [23:0] mem_addr_o;
  logic [7:0]  mem_wdata_o;
  logic [7:0]  mem_rdata_i = '0;
  logic        mem_rvalid_i = 1'b0, mem_wack_i = 1'b0;

  logic [7:0] mem [MEM_SZ];
  int lat = 0;
  int lat_cnt = 0;
  int acc_cnt = 0;
  int n_chk = 0;
  int n_fail = 0;
  int cyc = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  blkcopy_engine dut (
    .clk(clk), .rst(rst), .start_i(start_i), .src_i(src_i), .dst_i(dst_i),
    .cnt_i(cnt_i), .wide_i(wide_i), .busy_o(busy_o), .done_o(done_o),
    .src_o(src_o), .dst_o(dst_o), .cnt_o(cnt_o), .mem_req_o(mem_req_o),
    .mem_we_o(mem_we_o), .mem_addr_o(mem_addr_o), .mem_wdata_o(mem_wdata_o),
    .mem_rdata_i(mem_rdata_i), .mem_rvalid_i(mem_rvalid_i), .mem_wack_i(mem_wack_i)
  );

  // Memory responder, updated away from the active edge.
  always @(negedge clk) begin
    mem_rvalid_i = 1'b0;
    mem_wack_i   = 1'b0;
    if (rst) lat_cnt = 0;
    else if (mem_req_o) begin
      if (lat_cnt >= lat) begin
        lat_cnt = 0;
        acc_cnt++;
        if (mem_we_o) begin
          mem[mem_addr_o[11:0]] = mem_wdata_o;
          mem_wack_i = 1'b1;
        end else begin
          mem_rdata_i  = mem[mem_addr_o[11:0]];
          mem_rvalid_i = 1'b1;
        end
      end else lat_cnt++;
    end
  end

  always @(posedge clk) begin
    cyc++;
    if (cyc > WDOG) begin
      n_chk++; n_fail++;
      $display("FAIL watchdog: run hung, act=%0d exp<=%0d cycles", cyc, WDOG);
      $display("  == %0d vectors applied, %0d miscompares ==", n_chk, n_fail);
      $finish;
    end
  end

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: act=%h exp=%h", tag, act, exp);
    end
  endtask

  task automatic init_mem();
    for (int i = 0; i < MEM_SZ; i++) mem[i] = 8'(i * 7 + 3);
  endtask

  task automatic run_copy(input string name, input logic [31:0] s, input logic [31:0] d,
                          input logic [15:0] c, input logic w, input int l, input bit poke);
    int n, waits;
    logic [7:0] exp_b [];
    logic [7:0] guard;
    logic [31:0] es, ed;
    logic [15:0] ec;
    int acc0;
    bit bad;
    n  = w ? int'(c) : int'(c[7:0]);
    es = {8'h0, 24'(s[23:0] + 24'(n))};
    ed = {8'h0, 24'(d[23:0] + 24'(n))};
    ec = w ? 16'h0 : {c[15:8], 8'h00};
    exp_b = new[n];
    for (int i = 0; i < n; i++) exp_b[i] = mem[12'(s[23:0] + 24'(i))];
    guard = mem[12'(d[23:0] + 24'(n))];
    lat = l; acc0 = acc_cnt;
    @(negedge clk);
    start_i = 1'b1; src_i = s; dst_i = d; cnt_i = c; wide_i = w;
    @(negedge clk);
    start_i = 1'b0; src_i = 32'hDEAD_BEEF; dst_i = 32'h0BAD_F00D; cnt_i = 16'h0077; wide_i = ~w;
    chk({name, " R6 busy after start"}, 32'(busy_o), 32'd1);
    waits = 0;
    while (!done_o && waits < 20000) begin
      @(negedge clk);
      waits++;
      if (poke && waits == 3) begin
        start_i = 1'b1;            // R7: stray start while busy
        src_i = 32'h0000_0800; dst_i = 32'h0000_0900; cnt_i = 16'h0003; wide_i = 1'b1;
      end else start_i = 1'b0;
    end
    start_i = 1'b0;
    chk({name, " R6 done seen"}, 32'(done_o), 32'd1);
    chk({name, " R6 busy low with done"}, 32'(busy_o), 32'd0);
    if (n == 0) chk({name, " R3 zero-count done timing"}, 32'(waits), 32'd1);
    else if (l == 0) chk({name, " R4 step timing"}, 32'(waits), 32'(2 * n + 1));
    chk({name, " R3/R4/R7 access count"}, 32'(acc_cnt - acc0), 32'(2 * n));
    bad = 1'b0;
    for (int i = 0; i < n; i++)
      if (mem[12'(d[23:0] + 24'(i))] !== exp_b[i]) bad = 1'b1;
    chk({name, " R4 copied data"}, 32'(bad), 32'd0);
    chk({name, " R4 guard byte"}, 32'(mem[12'(d[23:0] + 24'(n))]), 32'(guard));
    chk({name, " R5 final src"}, src_o, es);
    chk({name, " R5 final dst"}, dst_o, ed);
    chk({name, w ? " R2 final count" : " R1 final count"}, 32'(cnt_o), 32'(ec));
    repeat (4) @(negedge clk);
    chk({name, " R6 done one cycle"}, 32'(done_o), 32'd0);
    chk({name, " R8 results held"}, {src_o ^ es} | {dst_o ^ ed} | 32'(cnt_o ^ ec), 32'd0);
  endtask

  task automatic t_reset();
    rst = 1'b1;
    repeat (3) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    chk("R9 busy after reset", 32'(busy_o), 32'd0);
    chk("R9 done after reset", 32'(done_o), 32'd0);
    chk("R9 req after reset", 32'(mem_req_o), 32'd0);
    chk("R9 outputs after reset", src_o | dst_o | 32'(cnt_o), 32'd0);
  endtask

  task automatic t_byte_mode();
    run_copy("byte-mode R1", 32'h0000_0040, 32'h0000_0200, 16'hAB05, 1'b0, 0, 1'b0);
    run_copy("byte-mode R1 lat2", 32'h0000_0060, 32'h0000_0280, 16'h0011, 1'b0, 2, 1'b0);
  endtask

  task automatic t_word_mode();
    run_copy("word-mode R2", 32'h0000_0300, 32'h0000_0500, 16'h0100, 1'b1, 0, 1'b0);
    run_copy("word-mode R2 lat1", 32'h0000_0010, 32'h0000_0700, 16'h0009, 1'b1, 1, 1'b0);
  endtask

  task automatic t_zero();
    run_copy("zero byte R3", 32'h0000_0020, 32'h0000_0A00, 16'h1200, 1'b0, 0, 1'b0);
    run_copy("zero word R3", 32'h0000_0020, 32'h0000_0A10, 16'h0000, 1'b1, 3, 1'b0);
  endtask

  task automatic t_wrap();
    run_copy("wrap R5", 32'hAB_FFFFFE, 32'h7700_0100, 16'h0004, 1'b0, 0, 1'b0);
  endtask

  task automatic t_busy_ignore();
    run_copy("stray-start R7", 32'h0000_0C00, 32'h0000_0D00, 16'h0006, 1'b1, 1, 1'b1);
  endtask

  initial begin
    init_mem();
    t_reset();
    t_byte_mode();
    t_word_mode();
    t_zero();
    t_wrap();
    t_busy_ignore();
    $display("  == %0d vectors applied, %0d miscompares ==", n_chk, n_fail);
    $finish;
  end
endmodule